// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a pin controller for general-purpose I/O with a small memory-mapped register port. Software sets each pin as an input or an output and reads or writes pin levels through a data register. An input pin that changes level can latch a sticky event bit. A mask register enables those event bits onto one level-sensitive interrupt line. An open-drain select register is stored and brought out per pin for the pad logic.

Pins are numbered from the most significant end: pin n owns register bit (31 - n). Every input pin passes through a two-flop synchronizer. A third flop holds the previous synchronized level, and edges are found by comparing it with the current one. A per-pin control bit chooses between event capture on any change and event capture on a falling edge only. Software clears event bits by writing ones to them.

The register port takes one access per cycle on a plain valid/write/size/address/data interface. Writes take effect at the next clock edge. Read data is combinational from the registers in the same cycle.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset all six registers read as zero, and `irq`, `pin_out`, `pin_oe` and `pin_od` are all zero.
- R2: Full-word accesses reach the registers at these byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, control 0x14. Direction, open-drain, mask and control read back the value last written.
- R3: A read at any other offset, including a misaligned one such as 0x02, returns zero. A write there changes no register.
- R4: Only accesses with `bus_size` = 2'b10 (32-bit) take effect. A read of any other size returns zero, and a write of any other size changes no register.
- R5: Pin n on `pin_in`, `pin_out`, `pin_oe` and `pin_od` corresponds to register bit (31 - n).
- R6: `pin_oe[n]` equals direction bit (31 - n). `pin_out[n]` equals data bit (31 - n) when that direction bit is 1, and is 0 otherwise.
- R7: For an input pin, the data bit takes the pin level that was applied three clock edges earlier. A change on the input of an output pin never alters that pin's data bit.
- R8: For an input pin whose control bit is 0, any change of the synchronized level sets its event bit. When the control bit is 1, only a high-to-low change sets it. Output pins never set event bits, and event bits stay set until software clears them.
- R9: Writing the event register clears each event bit whose written bit is 1 and leaves the others unchanged.
- R10: `irq` is high exactly when (event AND mask) is non-zero. A mask of zero forces `irq` low.
- R11: If a pin event and a software clear hit the same event bit on the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_size | input | 2 | Access size code, 2'b10 means 32-bit |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | N_PINS (32) | Write data |
| bus_rdata | output | N_PINS (32) | Read data, valid in the access cycle |
| pin_in | input | N_PINS (32) | Pin input levels, indexed by pin number |
| pin_out | output | N_PINS (32) | Pin output levels, indexed by pin number |
| pin_oe | output | N_PINS (32) | Output enable per pin |
| pin_od | output | N_PINS (32) | Open-drain select per pin |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- Event bits never drop without a write to the event register.
- Data bits of output pins never move without a write to the data register.
- A disabled pin never drives high.
- Accesses of the wrong size or to unmapped offsets leave state unchanged and read zero.
- A zero mask silences the interrupt.

Only the bench scenarios can show the following:
- The bit-reversed pin mapping.
- The three-edge input latency.
- The difference between any-edge and falling-only capture.
- The write-one-to-clear pattern.
- A hardware event winning against a clear on the same edge, which the bench times on purpose.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned OFS_DIR = 32'h00;
    localparam int unsigned OFS_ODR = 32'h04;
    localparam int unsigned OFS_DAT = 32'h08;
    localparam int unsigned OFS_EVT = 32'h0C;
    localparam int unsigned OFS_MSK = 32'h10;
    localparam int unsigned OFS_CTL = 32'h14;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_ODR,
        SEL_DAT,
        SEL_EVT,
        SEL_MSK,
        SEL_CTL
    } reg_sel_e;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (bus_valid && bus_size == SIZE_WORD) begin
            if      (bus_addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
            else if (bus_addr == ADDR_W'(OFS_ODR)) sel = SEL_ODR;
            else if (bus_addr == ADDR_W'(OFS_DAT)) sel = SEL_DAT;
            else if (bus_addr == ADDR_W'(OFS_EVT)) sel = SEL_EVT;
            else if (bus_addr == ADDR_W'(OFS_MSK)) sel = SEL_MSK;
            else if (bus_addr == ADDR_W'(OFS_CTL)) sel = SEL_CTL;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] level_d
);

    logic [WIDTH-1:0] stage1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i]  <= 1'b0;
                level[i]   <= 1'b0;
                level_d[i] <= 1'b0;
            end else begin
                stage1[i]  <= din[i];
                level[i]   <= stage1[i];
                level_d[i] <= level[i];
            end
        end
    end

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] level_d,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] ctl,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] evt
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic changed;
        logic falling;
        logic hit;
        logic cleared;

        assign changed = level[i] ^ level_d[i];
        assign falling = level_d[i] & ~level[i];
        assign hit     = ~dir[i] & (ctl[i] ? falling : changed);
        assign cleared = clr_en & clr_mask[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt[i] <= 1'b0;
            else        evt[i] <= hit | (evt[i] & ~cleared);
        end
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_od,
    output logic              irq
);

    localparam int MSB = N_PINS - 1;

    reg_sel_e          sel;
    logic [N_PINS-1:0] in_reg;
    logic [N_PINS-1:0] lvl;
    logic [N_PINS-1:0] lvl_d;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] odr_q;
    logic [N_PINS-1:0] dat_q;
    logic [N_PINS-1:0] evt_q;
    logic [N_PINS-1:0] msk_q;
    logic [N_PINS-1:0] ctl_q;
    logic              evt_clr;
    logic              dat_wr;

    gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .sel       (sel)
    );

    // Pin n maps to register bit MSB-n.
    for (genvar n = 0; n < N_PINS; n++) begin : g_pin
        assign in_reg[MSB-n] = pin_in[n];
        assign pin_out[n]    = dat_q[MSB-n] & dir_q[MSB-n];
        assign pin_oe[n]     = dir_q[MSB-n];
        assign pin_od[n]     = odr_q[MSB-n];
    end

    gpio_in_sync #(.WIDTH(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (in_reg),
        .level   (lvl),
        .level_d (lvl_d)
    );

    assign evt_clr = bus_write && (sel == SEL_EVT);
    assign dat_wr  = bus_write && (sel == SEL_DAT);

    gpio_event_unit #(.WIDTH(N_PINS)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl),
        .level_d  (lvl_d),
        .dir      (dir_q),
        .ctl      (ctl_q),
        .clr_en   (evt_clr),
        .clr_mask (bus_wdata),
        .evt      (evt_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            odr_q <= '0;
            msk_q <= '0;
            ctl_q <= '0;
        end else if (bus_write) begin
            case (sel)
                SEL_DIR: dir_q <= bus_wdata;
                SEL_ODR: odr_q <= bus_wdata;
                SEL_MSK: msk_q <= bus_wdata;
                SEL_CTL: ctl_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Output bits hold; input bits follow the synchronized level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dat_q <= '0;
        else if (dat_wr) dat_q <= bus_wdata;
        else             dat_q <= (dat_q & dir_q) | (lvl & ~dir_q);
    end

    assign irq = |(evt_q & msk_q);

    always_comb begin
        bus_rdata = '0;
        if (!bus_write) begin
            unique case (sel)
                SEL_DIR:  bus_rdata = dir_q;
                SEL_ODR:  bus_rdata = odr_q;
                SEL_DAT:  bus_rdata = dat_q;
                SEL_EVT:  bus_rdata = evt_q;
                SEL_MSK:  bus_rdata = msk_q;
                SEL_CTL:  bus_rdata = ctl_q;
                SEL_NONE: bus_rdata = '0;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] bus_rdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq,
    input logic [N_PINS-1:0] dir_q,
    input logic [N_PINS-1:0] odr_q,
    input logic [N_PINS-1:0] dat_q,
    input logic [N_PINS-1:0] evt_q,
    input logic [N_PINS-1:0] msk_q,
    input logic [N_PINS-1:0] ctl_q
);

    logic word_ok;
    logic mapped;
    logic wr_evt;
    logic wr_dat;
    logic wr_msk;

    assign word_ok = bus_valid && bus_size == SIZE_WORD;
    assign mapped  = bus_addr == ADDR_W'(OFS_DIR) || bus_addr == ADDR_W'(OFS_ODR) ||
                     bus_addr == ADDR_W'(OFS_DAT) || bus_addr == ADDR_W'(OFS_EVT) ||
                     bus_addr == ADDR_W'(OFS_MSK) || bus_addr == ADDR_W'(OFS_CTL);
    assign wr_evt  = word_ok && bus_write && bus_addr == ADDR_W'(OFS_EVT);
    assign wr_dat  = word_ok && bus_write && bus_addr == ADDR_W'(OFS_DAT);
    assign wr_msk  = word_ok && bus_write && bus_addr == ADDR_W'(OFS_MSK);

    p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dat |=> (((dat_q ^ $past(dat_q)) & $past(dir_q)) == '0));

    p_out_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_msk && bus_wdata == '0) |=> !irq);

    p_bad_size_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != SIZE_WORD) |=>
            ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(ctl_q)));

    p_bad_size_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size != SIZE_WORD) |-> bus_rdata == '0);

    p_unmapped_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !mapped) |-> bus_rdata == '0);

    p_unmapped_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !mapped) |=>
            ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(ctl_q)));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .dir_q     (dir_q),
    .odr_q     (odr_q),
    .dat_q     (dat_q),
    .evt_q     (evt_q),
    .msk_q     (msk_q),
    .ctl_q     (ctl_q)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;

    localparam logic [7:0] A_DIR = 8'h00;
    localparam logic [7:0] A_ODR = 8'h04;
    localparam logic [7:0] A_DAT = 8'h08;
    localparam logic [7:0] A_EVT = 8'h0C;
    localparam logic [7:0] A_MSK = 8'h10;
    localparam logic [7:0] A_CTL = 8'h14;
    localparam logic [1:0] WORD  = 2'b10;

    localparam int K_RDATA = 0;
    localparam int K_IRQ   = 1;
    localparam int K_POUT  = 2;
    localparam int K_POE   = 3;
    localparam int K_POD   = 4;

    typedef struct {
        int          kind;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = WORD;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] pin_od;
    logic        irq;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_od    (pin_od),
        .irq       (irq)
    );

    task automatic push(input int kind, input logic [31:0] val, input string tag);
        exp_t e;
        e.kind = kind;
        e.val  = val;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = WORD;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        push(K_RDATA, exp, tag);
        @(negedge clk);
        bus_valid = 1'b0; bus_size = WORD;
    endtask

    task automatic sig_chk(input int kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        push(kind, exp, tag);
    endtask

    task automatic set_pin(input int n, input logic v);
        @(negedge clk);
        pin_in[n] = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops expected items and compares against the design.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t        e;
                logic [31:0] act;
                e = sb_q.pop_front();
                case (e.kind)
                    K_RDATA: act = bus_rdata;
                    K_IRQ:   act = {31'b0, irq};
                    K_POUT:  act = pin_out;
                    K_POE:   act = pin_oe;
                    default: act = pin_od;
                endcase
                n_tests++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_DIR, WORD, 32'h0, "R1 dir");
        rd_chk(A_ODR, WORD, 32'h0, "R1 odr");
        rd_chk(A_DAT, WORD, 32'h0, "R1 dat");
        rd_chk(A_EVT, WORD, 32'h0, "R1 evt");
        rd_chk(A_MSK, WORD, 32'h0, "R1 msk");
        rd_chk(A_CTL, WORD, 32'h0, "R1 ctl");
        sig_chk(K_IRQ, 32'h0, "R1 irq");
        sig_chk(K_POUT, 32'h0, "R1 pin_out");

        // R2 R5 R6: pins 0 and 1 as outputs, pin 1 driven high
        bus_wr(A_DIR, 32'hC000_0000, WORD);
        rd_chk(A_DIR, WORD, 32'hC000_0000, "R2 dir readback");
        bus_wr(A_DAT, 32'h4000_0000, WORD);
        sig_chk(K_POE, 32'h0000_0003, "R6 R5 pin_oe");
        sig_chk(K_POUT, 32'h0000_0002, "R6 R5 pin_out");
        rd_chk(A_DAT, WORD, 32'h4000_0000, "R2 dat readback");
        bus_wr(A_ODR, 32'h0000_0005, WORD);
        rd_chk(A_ODR, WORD, 32'h0000_0005, "R2 odr readback");
        sig_chk(K_POD, 32'hA000_0000, "R5 pin_od");

        // R7 R8: pin 31 (bit 0) rises, any-edge mode
        set_pin(31, 1'b1);
        @(negedge clk);
        rd_chk(A_DAT, WORD, 32'h4000_0000, "R7 latency not yet");
        settle();
        rd_chk(A_DAT, WORD, 32'h4000_0001, "R7 input follows");
        rd_chk(A_EVT, WORD, 32'h0000_0001, "R8 rise event");
        sig_chk(K_IRQ, 32'h0, "R10 masked");

        // R10 mask enables irq
        bus_wr(A_MSK, 32'h0000_0001, WORD);
        rd_chk(A_MSK, WORD, 32'h0000_0001, "R2 msk readback");
        sig_chk(K_IRQ, 32'h1, "R10 irq high");

        // R9 write one to clear
        bus_wr(A_EVT, 32'h0, WORD);
        rd_chk(A_EVT, WORD, 32'h0000_0001, "R9 zero write keeps");
        bus_wr(A_EVT, 32'hFFFF_FFFE, WORD);
        rd_chk(A_EVT, WORD, 32'h0000_0001, "R9 other bits keep");
        bus_wr(A_EVT, 32'h0000_0001, WORD);
        rd_chk(A_EVT, WORD, 32'h0, "R9 cleared");
        sig_chk(K_IRQ, 32'h0, "R10 irq low after clear");

        // R8 falling-only on pin 31
        bus_wr(A_CTL, 32'h0000_0001, WORD);
        rd_chk(A_CTL, WORD, 32'h0000_0001, "R2 ctl readback");
        set_pin(31, 1'b0);
        settle();
        rd_chk(A_EVT, WORD, 32'h0000_0001, "R8 falling captured");
        sig_chk(K_IRQ, 32'h1, "R10 irq on fall");
        bus_wr(A_EVT, 32'h0000_0001, WORD);
        set_pin(31, 1'b1);
        settle();
        rd_chk(A_EVT, WORD, 32'h0, "R8 rise ignored in falling mode");
        rd_chk(A_DAT, WORD, 32'h4000_0001, "R7 level after rise");

        // R8 any-edge falling on pin 30 (bit 1), unmasked
        set_pin(30, 1'b1);
        settle();
        rd_chk(A_EVT, WORD, 32'h0000_0002, "R8 any-edge rise");
        bus_wr(A_EVT, 32'h0000_0002, WORD);
        set_pin(30, 1'b0);
        settle();
        rd_chk(A_EVT, WORD, 32'h0000_0002, "R8 any-edge fall");
        sig_chk(K_IRQ, 32'h0, "R10 bit1 not masked in");
        bus_wr(A_EVT, 32'h0000_0002, WORD);

        // R7 R8: input change on output pin 0 (bit 31)
        set_pin(0, 1'b1);
        settle();
        rd_chk(A_DAT, WORD, 32'h4000_0001, "R7 output bit unchanged");
        rd_chk(A_EVT, WORD, 32'h0, "R8 output pin no event");

        // R4 wrong access size
        bus_wr(A_MSK, 32'h0, 2'b01);
        rd_chk(A_MSK, WORD, 32'h0000_0001, "R4 short write ignored");
        rd_chk(A_DIR, 2'b01, 32'h0, "R4 short read zero");

        // R3 unmapped offsets
        bus_wr(8'h18, 32'hFFFF_FFFF, WORD);
        bus_wr(8'h01, 32'hFFFF_FFFF, WORD);
        rd_chk(8'h18, WORD, 32'h0, "R3 unmapped read");
        rd_chk(8'h02, WORD, 32'h0, "R3 misaligned read");
        rd_chk(A_DIR, WORD, 32'hC000_0000, "R3 dir untouched");
        rd_chk(A_DAT, WORD, 32'h4000_0001, "R3 dat untouched");

        // R11 event beats clear on the same edge (pin 31 falls, falling mode)
        set_pin(31, 1'b0);
        @(negedge clk);
        bus_wr(A_EVT, 32'h0000_0001, WORD);
        rd_chk(A_EVT, WORD, 32'h0000_0001, "R11 set wins");
        sig_chk(K_IRQ, 32'h1, "R11 irq stays");

        // R6 output goes low on data write
        bus_wr(A_DAT, 32'h0, WORD);
        sig_chk(K_POUT, 32'h0, "R6 pin_out low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule